// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block sits between a processor and memory. It turns a 32-bit virtual address into a 24-bit physical address by reading one entry from a single-level page table. The page table lives in an external memory with a synchronous read port. Pages are 4 KiB. The upper 20 address bits select a table entry, and the lower 12 bits pass through unchanged as the offset inside the page.

A request is taken while the block is idle and no fault is pending. If the entry is valid, the block returns the physical address built from the entry's frame number and the offset. A store that hits a clean page first writes the entry back with its dirty bit set. If the entry is invalid, or the page number lies beyond the table depth, the block raises a fault interrupt and holds the faulting page number. Software then loads the page, fixes the table and acknowledges the fault.

Top module: `vaddr_translator`

## Requirements
- R1: After reset, req_ready is 1 and resp_valid, fault_irq, pt_rd_en and pt_we are all 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. In the following cycle the block asserts pt_rd_en for exactly one cycle, with pt_addr equal to the low IDX_W bits of vaddr[31:12].
- R3: A table entry is 14 bits: bit 13 is valid, bit 12 is dirty and bits 11:0 are the frame number. For a valid entry, resp_valid is high for exactly one cycle, in the cycle after pt_rdata is presented. In that cycle resp_paddr equals {frame, vaddr[11:0]}. For example, page 3 mapped to frame 6 gives a frame field of 6.
- R4: The offset bits vaddr[11:0] appear unchanged in resp_paddr[11:0], including the values 0x000 and 0xFFF.
- R5: A store (req_write=1) that hits a valid entry with dirty=0 causes one pt_we pulse. The pulse comes in the cycle pt_rdata is presented, at the same pt_addr, with pt_wdata equal to the entry with bit 12 set. The response follows in the next cycle.
- R6: A load, or a store to an entry whose dirty bit is already 1, never asserts pt_we.
- R7: When the entry's valid bit is 0, the block gives no response. fault_irq rises in the cycle after pt_rdata is presented, and fault_vpn holds the full 20-bit page number.
- R8: fault_irq stays high until a cycle with fault_ack high, and falls after that edge. While it is high, req_ready is 0, no request is accepted and no table read is issued.
- R9: A page number greater than or equal to TBL_DEPTH faults with the same timing as R7 and issues no table read.
- R10: From acceptance until the response or fault appears, req_ready is 0. Only one request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_write | input | 1 | Request is a store |
| req_vaddr | input | 32 | Virtual address |
| req_ready | output | 1 | Block can accept a request |
| resp_valid | output | 1 | Translation done pulse |
| resp_paddr | output | 24 | Physical address |
| fault_irq | output | 1 | Page-fault interrupt, held until acknowledged |
| fault_vpn | output | 20 | Faulting page number |
| fault_ack | input | 1 | Clears the pending fault |
| pt_rd_en | output | 1 | Page-table read strobe |
| pt_addr | output | IDX_W | Page-table entry index |
| pt_rdata | input | 14 | Entry read data, one cycle after the strobe |
| pt_we | output | 1 | Page-table write strobe |
| pt_wdata | output | 14 | Entry write data |

## Verification
The bench targets these corner cases:
- **Off-by-one response:** a response issued one cycle early or late would carry a stale frame, or would not line up with the cycle after the read data.
- **Wrong write-back decision:** stores to clean and already-dirty pages, and loads, are mixed. A design that writes on every store, or never writes, shows the wrong pt_we count or leaves the dirty bit clear, and the next store to that page shows it.
- **Weak fault hold:** requests are held on the bus while a fault is pending. A block that lets them in, or drops the interrupt early, issues extra table reads.
- **Out-of-range pages:** a page number past the table depth, with high bits set, exposes a truncated fault_vpn and any table read that should have been blocked.
- **Offset corruption:** offsets 0x000 and 0xFFF catch an offset that was clipped or mixed into the frame.

// File: rtl/vxl_pkg.sv
package vxl_pkg;
  localparam int VA_W    = 32;
  localparam int OFF_W   = 12;
  localparam int FRAME_W = 12;
  localparam int VPN_W   = VA_W - OFF_W;
  localparam int PA_W    = FRAME_W + OFF_W;
  localparam int PTE_W   = FRAME_W + 2;

  typedef struct packed {
    logic               valid;
    logic               dirty;
    logic [FRAME_W-1:0] frame;
  } pte_t;

  function automatic logic [VPN_W-1:0] vpn_of(input logic [VA_W-1:0] va);
    return va[VA_W-1:OFF_W];
  endfunction

  function automatic logic [OFF_W-1:0] off_of(input logic [VA_W-1:0] va);
    return va[OFF_W-1:0];
  endfunction

  function automatic logic [PA_W-1:0] join_paddr(input logic [FRAME_W-1:0] fr,
                                                 input logic [OFF_W-1:0] off);
    return {fr, off};
  endfunction

  function automatic pte_t mark_dirty(input pte_t e);
    pte_t r;
    r       = e;
    r.dirty = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/xlate_seq.sv
module xlate_seq
  import vxl_pkg::*;
#(
  parameter int TBL_DEPTH = 1 << 20,
  localparam int IDX_W = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              fault_pending,
  input  pte_t              pte_in,
  output logic              req_ready,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              wb_en,
  output pte_t              wb_pte,
  output logic              hit_evt,
  output logic              fault_evt,
  output logic [PA_W-1:0]   hit_paddr,
  output logic [VPN_W-1:0]  cur_vpn
);
  typedef enum logic [1:0] {S_IDLE, S_LOOK, S_CHECK} st_t;

  localparam logic [VPN_W:0] DEPTH_V = (VPN_W+1)'(TBL_DEPTH);

  st_t             st;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic            oor_q;
  logic            accept;
  logic            req_oor;

  assign req_ready = (st == S_IDLE) && !fault_pending;
  assign accept    = req_ready && req_valid;
  assign req_oor   = {1'b0, vpn_of(req_vaddr)} >= DEPTH_V;
  assign cur_vpn   = vpn_of(va_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      va_q  <= '0;
      wr_q  <= 1'b0;
      oor_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st    <= S_LOOK;
          va_q  <= req_vaddr;
          wr_q  <= req_write;
          oor_q <= req_oor;
        end
        S_LOOK:  st <= S_CHECK;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_en     = (st == S_LOOK) && !oor_q;
    rd_idx    = cur_vpn[IDX_W-1:0];
    hit_evt   = (st == S_CHECK) && !oor_q && pte_in.valid;
    fault_evt = (st == S_CHECK) && (oor_q || !pte_in.valid);
    wb_en     = hit_evt && wr_q && !pte_in.dirty;
    wb_pte    = mark_dirty(pte_in);
    hit_paddr = join_paddr(pte_in.frame, off_of(va_q));
  end

  assert_read_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_oor) |=> rd_en);
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !req_ready);
  assert_no_read_oor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_oor) |=> !rd_en);
  assert_wb_sets_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_pte.dirty && wb_pte.valid && !pte_in.dirty));
endmodule

// File: rtl/fault_hold.sv
module fault_hold
  import vxl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_evt,
  input  logic [VPN_W-1:0] set_vpn,
  input  logic             ack,
  output logic             irq,
  output logic [VPN_W-1:0] vpn
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      vpn <= '0;
    end else if (set_evt) begin
      irq <= 1'b1;
      vpn <= set_vpn;
    end else if (ack) begin
      irq <= 1'b0;
    end
  end

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ack) |=> irq);
  assert_vpn_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !set_evt) |=> $stable(vpn));
endmodule

// File: rtl/vaddr_translator.sv
module vaddr_translator
  import vxl_pkg::*;
#(
  parameter int TBL_DEPTH = 1 << 20,
  localparam int IDX_W = $clog2(TBL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              req_ready,
  output logic              resp_valid,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              fault_irq,
  output logic [VPN_W-1:0]  fault_vpn,
  input  logic              fault_ack,
  output logic              pt_rd_en,
  output logic [IDX_W-1:0]  pt_addr,
  input  logic [PTE_W-1:0]  pt_rdata,
  output logic              pt_we,
  output logic [PTE_W-1:0]  pt_wdata
);
  pte_t             pte_in;
  pte_t             wb_pte;
  logic             hit_evt;
  logic             fault_evt;
  logic [PA_W-1:0]  hit_paddr;
  logic [VPN_W-1:0] cur_vpn;

  assign pte_in   = pte_t'(pt_rdata);
  assign pt_wdata = PTE_W'(wb_pte);

  xlate_seq #(.TBL_DEPTH(TBL_DEPTH)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_vaddr    (req_vaddr),
    .fault_pending(fault_irq),
    .pte_in       (pte_in),
    .req_ready    (req_ready),
    .rd_en        (pt_rd_en),
    .rd_idx       (pt_addr),
    .wb_en        (pt_we),
    .wb_pte       (wb_pte),
    .hit_evt      (hit_evt),
    .fault_evt    (fault_evt),
    .hit_paddr    (hit_paddr),
    .cur_vpn      (cur_vpn)
  );

  fault_hold u_fault (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(fault_evt),
    .set_vpn(cur_vpn),
    .ack    (fault_ack),
    .irq    (fault_irq),
    .vpn    (fault_vpn)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_paddr <= '0;
    end else begin
      resp_valid <= hit_evt;
      if (hit_evt) resp_paddr <= hit_paddr;
    end
  end

  assert_resp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);
  assert_hit_fault_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_evt && fault_evt));
  assert_no_resp_with_new_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (!resp_valid && fault_irq));
endmodule

// File: tb/tb_vaddr_translator.sv
module tb_vaddr_translator;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 256;
  localparam int IW         = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        resp_valid;
  logic [23:0] resp_paddr;
  logic        fault_irq;
  logic [19:0] fault_vpn;
  logic        fault_ack = 1'b0;
  logic        pt_rd_en;
  logic [IW-1:0] pt_addr;
  logic [13:0] pt_rdata = '0;
  logic        pt_we;
  logic [13:0] pt_wdata;

  logic [13:0] mem [DEPTH];
  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  int we_cnt = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vaddr_translator #(.TBL_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_paddr(resp_paddr), .fault_irq(fault_irq), .fault_vpn(fault_vpn),
    .fault_ack(fault_ack), .pt_rd_en(pt_rd_en), .pt_addr(pt_addr),
    .pt_rdata(pt_rdata), .pt_we(pt_we), .pt_wdata(pt_wdata)
  );

  always @(posedge clk) begin
    if (pt_rd_en) pt_rdata <= mem[pt_addr];
    if (pt_we) mem[pt_addr] <= pt_wdata;
  end

  always @(negedge clk) begin
    if (pt_rd_en) rd_cnt++;
    if (pt_we) we_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
      finish_run();
    end
  end

  // kind: 0 hit, 1 fault (invalid), 2 fault (out of range)
  task automatic run_req(input string tag, input logic wr, input logic [31:0] va,
                         input int kind, input logic [23:0] exp_pa, input logic exp_we,
                         input logic [13:0] exp_wdata);
    int rd0;
    int we0;
    rd0 = rd_cnt;
    we0 = we_cnt;
    @(negedge clk);
    check({tag, " R10 ready idle"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check({tag, " R10 busy"}, 32'(req_ready), 32'd0);
    if (kind == 2) begin
      check({tag, " R9 no read"}, 32'(pt_rd_en), 32'd0);
    end else begin
      check({tag, " R2 read strobe"}, 32'(pt_rd_en), 32'd1);
      check({tag, " R2 read index"}, 32'(pt_addr), 32'(va[12 +: IW]));
    end
    @(negedge clk);
    check({tag, " R5/R6 write strobe"}, 32'(pt_we), 32'(exp_we));
    if (exp_we) check({tag, " R5 write data"}, 32'(pt_wdata), 32'(exp_wdata));
    check({tag, " R10 busy check"}, 32'(req_ready), 32'd0);
    @(negedge clk);
    if (kind == 0) begin
      check({tag, " R3 resp_valid"}, 32'(resp_valid), 32'd1);
      check({tag, " R3 paddr"}, 32'(resp_paddr), 32'(exp_pa));
      check({tag, " R4 offset"}, 32'(resp_paddr[11:0]), 32'(va[11:0]));
      @(negedge clk);
      check({tag, " R3 single pulse"}, 32'(resp_valid), 32'd0);
    end else begin
      check({tag, " R7 no response"}, 32'(resp_valid), 32'd0);
      check({tag, " R7 fault_irq"}, 32'(fault_irq), 32'd1);
      check({tag, " R7 fault_vpn"}, 32'(fault_vpn), 32'(va[31:12]));
    end
    check({tag, " R2/R9 read count"}, 32'(rd_cnt - rd0), (kind == 2) ? 32'd0 : 32'd1);
    check({tag, " R5/R6 write count"}, 32'(we_cnt - we0), 32'(exp_we));
  endtask

  task automatic do_ack();
    @(negedge clk);
    fault_ack = 1'b1;
    @(negedge clk);
    fault_ack = 1'b0;
    check("R8 irq cleared", 32'(fault_irq), 32'd0);
    check("R8 ready after ack", 32'(req_ready), 32'd1);
  endtask

  task automatic t_reset();
    check("R1 req_ready", 32'(req_ready), 32'd1);
    check("R1 resp_valid", 32'(resp_valid), 32'd0);
    check("R1 fault_irq", 32'(fault_irq), 32'd0);
    check("R1 pt_rd_en", 32'(pt_rd_en), 32'd0);
    check("R1 pt_we", 32'(pt_we), 32'd0);
  endtask

  task automatic t_read_hits();
    run_req("page3", 1'b0, 32'h0000_3ABC, 0, 24'h006ABC, 1'b0, '0);
    run_req("off0", 1'b0, 32'h0000_5000, 0, 24'hFED000, 1'b0, '0);
    run_req("offmax", 1'b0, 32'h0000_5FFF, 0, 24'hFEDFFF, 1'b0, '0);
  endtask

  task automatic t_store_clean();
    run_req("store clean", 1'b1, 32'h0000_7123, 0, 24'h042123, 1'b1, 14'h3042);
    check("R5 table dirty set", 32'(mem[7]), 32'h3042);
    run_req("store again", 1'b1, 32'h0000_7456, 0, 24'h042456, 1'b0, '0);
  endtask

  task automatic t_store_dirty();
    run_req("store dirty", 1'b1, 32'h0000_9001, 0, 24'h0AB001, 1'b0, '0);
    run_req("load clean", 1'b0, 32'h0000_A002, 0, 24'h0CD002, 1'b0, '0);
    check("R6 clean stays clean", 32'(mem[10]), 32'h20CD);
  endtask

  task automatic t_fault_hold();
    int rd0;
    run_req("invalid", 1'b0, 32'h0000_2777, 1, '0, 1'b0, '0);
    rd0 = rd_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = 32'h0000_3000;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R8 ready low while pending", 32'(req_ready), 32'd0);
      check("R8 irq held", 32'(fault_irq), 32'd1);
    end
    req_valid = 1'b0;
    check("R8 no reads while pending", 32'(rd_cnt - rd0), 32'd0);
    do_ack();
    run_req("after ack", 1'b0, 32'h0000_3001, 0, 24'h006001, 1'b0, '0);
  endtask

  task automatic t_out_of_range();
    run_req("oor", 1'b1, 32'hABCD_E123, 2, '0, 1'b0, '0);
    do_ack();
    run_req("oor edge", 1'b0, 32'h0010_0000, 2, '0, 1'b0, '0);
    do_ack();
    run_req("last page", 1'b0, 32'h000F_F800, 0, 24'h111800, 1'b0, '0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 14'h0000;
    mem[3]   = {1'b1, 1'b0, 12'h006};
    mem[5]   = {1'b1, 1'b1, 12'hFED};
    mem[7]   = {1'b1, 1'b0, 12'h042};
    mem[9]   = {1'b1, 1'b1, 12'h0AB};
    mem[10]  = {1'b1, 1'b0, 12'h0CD};
    mem[255] = {1'b1, 1'b0, 12'h111};
    mem[2]   = {1'b0, 1'b0, 12'h999};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_hits();
    t_store_clean();
    t_store_dirty();
    t_fault_hold();
    t_out_of_range();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule